// File: doc/BRIEF.md
# Gated model-specific register bank

This block is a bank of 64-bit model-specific registers. A privileged requester reaches it through an address-decoded read/write port. Every request gets an answer one clock later: a response with read data, or a single-cycle fault. The bank holds five kinds of register:

- a system-configuration register whose four enable bits change how the fixed-range memory-type registers may be accessed, and which are also driven out to downstream memory-typing logic;
- a pair of segment-base registers that a swap strobe exchanges in one cycle;
- a free-running cycle counter that software can load;
- a user-mode counter read path that a disable input can block;
- a small set of fixed-range memory-type registers whose read-memory and write-memory attribute bits are gated by the configuration register.

Instruction decode, privilege logic beyond one input flag, and the memory-type lookup itself are outside the block.

Top module: `msr_bank`

## Requirements
- R1: The configuration register at address 0xC001_0010 stores only bits 18 (attribute enable), 19 (attribute-modify enable), 20 (top-of-memory 1 enable) and 21 (top-of-memory 2 enable). All other bits are dropped on write and read as 0.
- R2: The fixed-range registers sit at 0x0000_0250 + i, with i from 0 to NUM_FIX-1. Each byte lane holds a type in bits 2:0, a write-memory attribute in bit 3 and a read-memory attribute in bit 4. Bits 7:5 always read 0. While configuration bit 19 is 0, a write leaves bits 3 and 4 of every lane unchanged and a read returns them as 0. While bit 19 is 1, bits 3 and 4 are written and read normally.
- R3: The outputs attr_en, attr_mod_en, tom1_en and tom2_en follow configuration bits 18, 19, 20 and 21. They change in the cycle after an accepted configuration write and at no other time.
- R4: A swap_gs pulse exchanges the segment-base register (0xC000_0101) and the kernel segment-base register (0xC000_0102) at one clock edge.
- R5: The cycle counter at 0x0000_0010 increments on every clock. A read returns the counter value at the clock edge that accepts the request.
- R6: A write to the cycle counter loads the written value, and counting resumes from that value at the following clock.
- R7: A ucnt_rd pulse with tsc_dis=0 gives ucnt_valid=1 one cycle later, with ucnt_data equal to the counter value at the request edge. With tsc_dis=1 it gives ucnt_fault=1 and ucnt_valid=0 instead.
- R8: A request with req_priv=0 raises fault for one cycle, gives no response, and changes no register.
- R9: A privileged request to an address that holds no register raises fault for one cycle and changes no register.
- R10: An accepted request raises rsp_valid for one cycle, in the cycle after the request. rsp_rdata carries the read value for a read and 0 for a write.
- R11: Reset clears every register and every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | Requester is privileged |
| req_addr | input | 32 | Register address |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Accepted-request response |
| rsp_rdata | output | 64 | Read data (0 for writes) |
| fault | output | 1 | Rejected request |
| swap_gs | input | 1 | Exchange the two segment-base registers |
| ucnt_rd | input | 1 | User-mode counter read request |
| tsc_dis | input | 1 | Blocks user-mode counter reads |
| ucnt_valid | output | 1 | User-mode counter read succeeded |
| ucnt_data | output | 64 | Counter value for user-mode read |
| ucnt_fault | output | 1 | User-mode counter read refused |
| attr_en | output | 1 | Fixed-range attribute enable |
| attr_mod_en | output | 1 | Fixed-range attribute modify enable |
| tom1_en | output | 1 | First top-of-memory and variable I/O range enable |
| tom2_en | output | 1 | Second top-of-memory enable |

## Verification
The swap property assumes that no port request is active in the swap cycle. If a write to a segment-base register coincides with a swap, the write wins for that register, and the property does not describe that case. The bench therefore issues swaps only in cycles with no port request. All properties also assume that the request inputs hold defined values once reset is released. The bench drives every input to a known value before reset ends and changes inputs only on falling edges.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int MSR_W  = 64;
    localparam int ADDR_W = 32;
    localparam int LANES  = MSR_W / 8;

    localparam logic [ADDR_W-1:0] ADDR_CFG  = 32'hC001_0010;
    localparam logic [ADDR_W-1:0] ADDR_CNT  = 32'h0000_0010;
    localparam logic [ADDR_W-1:0] ADDR_GS   = 32'hC000_0101;
    localparam logic [ADDR_W-1:0] ADDR_KGS  = 32'hC000_0102;
    localparam logic [ADDR_W-1:0] ADDR_FIX0 = 32'h0000_0250;

    localparam int BIT_ATTR_EN  = 18;
    localparam int BIT_ATTR_MOD = 19;
    localparam int BIT_TOM1     = 20;
    localparam int BIT_TOM2     = 21;

    localparam logic [MSR_W-1:0] CFG_KEEP = (64'h1 << BIT_ATTR_EN) | (64'h1 << BIT_ATTR_MOD)
                                          | (64'h1 << BIT_TOM1)    | (64'h1 << BIT_TOM2);

    localparam logic [7:0] LANE_TYPE = 8'h07;
    localparam logic [7:0] LANE_ATTR = 8'h18;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_CNT,
        SEL_GS,
        SEL_KGS,
        SEL_FIX
    } sel_e;

    function automatic logic [MSR_W-1:0] spread(input logic [7:0] lane);
        logic [MSR_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i*8 +: 8] = lane;
        end
        return m;
    endfunction

endpackage

// File: rtl/msr_decode.sv
module msr_decode
    import msr_pkg::*;
#(
    parameter int NUM_FIX = 4,
    localparam int IDX_W  = (NUM_FIX > 1) ? $clog2(NUM_FIX) : 1
) (
    input  logic              valid,
    input  logic              priv,
    input  logic [ADDR_W-1:0] addr,
    output sel_e              kind,
    output logic [IDX_W-1:0]  fix_idx,
    output logic              accept,
    output logic              reject
);

    logic [ADDR_W-1:0] fix_off;

    always_comb begin
        fix_off = addr - ADDR_FIX0;
        fix_idx = fix_off[IDX_W-1:0];
        if (addr == ADDR_CFG) begin
            kind = SEL_CFG;
        end else if (addr == ADDR_CNT) begin
            kind = SEL_CNT;
        end else if (addr == ADDR_GS) begin
            kind = SEL_GS;
        end else if (addr == ADDR_KGS) begin
            kind = SEL_KGS;
        end else if (fix_off < ADDR_W'(NUM_FIX)) begin
            kind = SEL_FIX;
        end else begin
            kind = SEL_NONE;
        end
        accept = valid && priv && (kind != SEL_NONE);
        reject = valid && !accept;
    end

endmodule

// File: rtl/msr_fix_lane.sv
module msr_fix_lane
    import msr_pkg::*;
(
    input  logic [MSR_W-1:0] cur,
    input  logic [MSR_W-1:0] wdata,
    input  logic             mod_en,
    output logic [MSR_W-1:0] wr_val,
    output logic [MSR_W-1:0] rd_val
);

    for (genvar b = 0; b < LANES; b++) begin : g_byte
        logic [7:0] cur_b;
        logic [7:0] new_b;
        always_comb begin
            cur_b = cur[b*8 +: 8];
            new_b = wdata[b*8 +: 8];
            if (mod_en) begin
                wr_val[b*8 +: 8] = new_b & (LANE_TYPE | LANE_ATTR);
                rd_val[b*8 +: 8] = cur_b & (LANE_TYPE | LANE_ATTR);
            end else begin
                wr_val[b*8 +: 8] = (new_b & LANE_TYPE) | (cur_b & LANE_ATTR);
                rd_val[b*8 +: 8] = cur_b & LANE_TYPE;
            end
        end
    end

endmodule

// File: rtl/msr_bank.sv
module msr_bank
    import msr_pkg::*;
#(
    parameter int NUM_FIX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [MSR_W-1:0]  req_wdata,
    output logic              rsp_valid,
    output logic [MSR_W-1:0]  rsp_rdata,
    output logic              fault,
    input  logic              swap_gs,
    input  logic              ucnt_rd,
    input  logic              tsc_dis,
    output logic              ucnt_valid,
    output logic [MSR_W-1:0]  ucnt_data,
    output logic              ucnt_fault,
    output logic              attr_en,
    output logic              attr_mod_en,
    output logic              tom1_en,
    output logic              tom2_en
);

    localparam int IDX_W = (NUM_FIX > 1) ? $clog2(NUM_FIX) : 1;

    typedef struct packed {
        logic [MSR_W-1:0]              cfg;
        logic [MSR_W-1:0]              cnt;
        logic [MSR_W-1:0]              gs;
        logic [MSR_W-1:0]              kgs;
        logic [NUM_FIX-1:0][MSR_W-1:0] fix;
        logic                          rsp_valid;
        logic [MSR_W-1:0]              rsp_rdata;
        logic                          fault;
        logic                          ucnt_valid;
        logic [MSR_W-1:0]              ucnt_data;
        logic                          ucnt_fault;
    } state_t;

    state_t st_d, st_q;

    sel_e                          kind;
    logic [IDX_W-1:0]              fix_idx;
    logic                          accept;
    logic                          reject;
    logic [NUM_FIX-1:0][MSR_W-1:0] fix_wr;
    logic [NUM_FIX-1:0][MSR_W-1:0] fix_rd;

    msr_decode #(.NUM_FIX(NUM_FIX)) u_decode (
        .valid   (req_valid),
        .priv    (req_priv),
        .addr    (req_addr),
        .kind    (kind),
        .fix_idx (fix_idx),
        .accept  (accept),
        .reject  (reject)
    );

    for (genvar g = 0; g < NUM_FIX; g++) begin : g_fix
        msr_fix_lane u_lane (
            .cur    (st_q.fix[g]),
            .wdata  (req_wdata),
            .mod_en (st_q.cfg[BIT_ATTR_MOD]),
            .wr_val (fix_wr[g]),
            .rd_val (fix_rd[g])
        );
    end

    always_comb begin
        st_d            = st_q;
        st_d.rsp_valid  = 1'b0;
        st_d.rsp_rdata  = '0;
        st_d.fault      = 1'b0;
        st_d.ucnt_valid = 1'b0;
        st_d.ucnt_data  = '0;
        st_d.ucnt_fault = 1'b0;
        st_d.cnt        = st_q.cnt + MSR_W'(1);

        if (swap_gs) begin
            st_d.gs  = st_q.kgs;
            st_d.kgs = st_q.gs;
        end

        if (accept) begin
            st_d.rsp_valid = 1'b1;
            if (req_write) begin
                unique case (kind)
                    SEL_CFG: st_d.cfg = req_wdata & CFG_KEEP;
                    SEL_CNT: st_d.cnt = req_wdata;
                    SEL_GS:  st_d.gs  = req_wdata;
                    SEL_KGS: st_d.kgs = req_wdata;
                    SEL_FIX: st_d.fix[fix_idx] = fix_wr[fix_idx];
                    default: ;
                endcase
            end else begin
                unique case (kind)
                    SEL_CFG: st_d.rsp_rdata = st_q.cfg;
                    SEL_CNT: st_d.rsp_rdata = st_q.cnt;
                    SEL_GS:  st_d.rsp_rdata = st_q.gs;
                    SEL_KGS: st_d.rsp_rdata = st_q.kgs;
                    SEL_FIX: st_d.rsp_rdata = fix_rd[fix_idx];
                    default: st_d.rsp_rdata = '0;
                endcase
            end
        end

        if (reject) begin
            st_d.fault = 1'b1;
        end

        if (ucnt_rd) begin
            if (tsc_dis) begin
                st_d.ucnt_fault = 1'b1;
            end else begin
                st_d.ucnt_valid = 1'b1;
                st_d.ucnt_data  = st_q.cnt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid   = st_q.rsp_valid;
    assign rsp_rdata   = st_q.rsp_rdata;
    assign fault       = st_q.fault;
    assign ucnt_valid  = st_q.ucnt_valid;
    assign ucnt_data   = st_q.ucnt_data;
    assign ucnt_fault  = st_q.ucnt_fault;
    assign attr_en     = st_q.cfg[BIT_ATTR_EN];
    assign attr_mod_en = st_q.cfg[BIT_ATTR_MOD];
    assign tom1_en     = st_q.cfg[BIT_TOM1];
    assign tom2_en     = st_q.cfg[BIT_TOM2];

endmodule

// File: rtl/msr_bank_chk.sv
module msr_bank_chk
    import msr_pkg::*;
#(
    parameter int NUM_FIX = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_write,
    input logic                     req_priv,
    input logic [ADDR_W-1:0]        req_addr,
    input logic                     swap_gs,
    input logic                     ucnt_rd,
    input logic                     tsc_dis,
    input logic                     rsp_valid,
    input logic [MSR_W-1:0]         rsp_rdata,
    input logic                     fault,
    input logic                     ucnt_valid,
    input logic [MSR_W-1:0]         ucnt_data,
    input logic                     ucnt_fault,
    input logic                     attr_en,
    input logic                     attr_mod_en,
    input logic                     tom1_en,
    input logic                     tom2_en,
    input logic [MSR_W-1:0]         cfg,
    input logic [MSR_W-1:0]         cnt,
    input logic [MSR_W-1:0]         gs,
    input logic [MSR_W-1:0]         kgs,
    input logic [NUM_FIX*MSR_W-1:0] fix
);

    localparam logic [NUM_FIX*MSR_W-1:0] ATTR_ALL = {NUM_FIX{spread(LANE_ATTR)}};

    logic wr_any;
    logic wr_cfg;
    logic wr_cnt;

    assign wr_any = req_valid && req_write && req_priv;
    assign wr_cfg = wr_any && (req_addr == ADDR_CFG);
    assign wr_cnt = wr_any && (req_addr == ADDR_CNT);

    p_cfg_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg & ~CFG_KEEP) == '0);

    p_attr_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !attr_mod_en |=> (fix & ATTR_ALL) == ($past(fix) & ATTR_ALL));

    p_enables_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cfg |=> $stable({attr_en, attr_mod_en, tom1_en, tom2_en}));

    p_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_gs && !req_valid) |=> (gs == $past(kgs)) && (kgs == $past(gs)));

    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cnt |=> cnt == $past(cnt) + MSR_W'(1));

    p_ucnt_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ucnt_rd && !tsc_dis) |=> ucnt_valid && !ucnt_fault && (ucnt_data == $past(cnt)));

    p_ucnt_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ucnt_rd && tsc_dis) |=> ucnt_fault && !ucnt_valid);

    p_unpriv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_priv) |=> fault && !rsp_valid && $stable(cfg) && $stable(fix));

    p_write_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cfg |=> rsp_valid && !fault && (rsp_rdata == '0));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !fault);

endmodule

bind msr_bank msr_bank_chk #(.NUM_FIX(NUM_FIX)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_priv    (req_priv),
    .req_addr    (req_addr),
    .swap_gs     (swap_gs),
    .ucnt_rd     (ucnt_rd),
    .tsc_dis     (tsc_dis),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .fault       (fault),
    .ucnt_valid  (ucnt_valid),
    .ucnt_data   (ucnt_data),
    .ucnt_fault  (ucnt_fault),
    .attr_en     (attr_en),
    .attr_mod_en (attr_mod_en),
    .tom1_en     (tom1_en),
    .tom2_en     (tom2_en),
    .cfg         (st_q.cfg),
    .cnt         (st_q.cnt),
    .gs          (st_q.gs),
    .kgs         (st_q.kgs),
    .fix         (st_q.fix)
);

// File: tb/test_msr_bank.sv
module test_msr_bank;

    localparam int NF = 4;

    localparam logic [31:0] A_CFG  = 32'hC001_0010;
    localparam logic [31:0] A_CNT  = 32'h0000_0010;
    localparam logic [31:0] A_GS   = 32'hC000_0101;
    localparam logic [31:0] A_KGS  = 32'hC000_0102;
    localparam logic [31:0] A_FIX0 = 32'h0000_0250;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_priv = 1'b0;
    logic [31:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        swap_gs = 1'b0;
    logic        ucnt_rd = 1'b0;
    logic        tsc_dis = 1'b0;
    logic        rsp_valid, fault, ucnt_valid, ucnt_fault;
    logic [63:0] rsp_rdata, ucnt_data;
    logic        attr_en, attr_mod_en, tom1_en, tom2_en;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    msr_bank #(.NUM_FIX(NF)) i_msr_bank (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_priv(req_priv),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .fault(fault),
        .swap_gs(swap_gs), .ucnt_rd(ucnt_rd), .tsc_dis(tsc_dis),
        .ucnt_valid(ucnt_valid), .ucnt_data(ucnt_data), .ucnt_fault(ucnt_fault),
        .attr_en(attr_en), .attr_mod_en(attr_mod_en), .tom1_en(tom1_en), .tom2_en(tom2_en)
    );

    typedef struct {
        logic        valid;
        logic        flt;
        logic [63:0] data;
        string       req;
    } exp_t;

    exp_t sb[$];

    logic [63:0] cfg_m = '0, gs_m = '0, kgs_m = '0, cnt_m = '0;
    logic [63:0] fix_m [NF];

    function automatic logic [63:0] rep(input logic [7:0] b);
        logic [63:0] m;
        for (int i = 0; i < 8; i++) m[i*8 +: 8] = b;
        return m;
    endfunction

    // Counter model built from R5 and R6
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_m <= '0;
        else if (req_valid && req_write && req_priv && req_addr == A_CNT) cnt_m <= req_wdata;
        else cnt_m <= cnt_m + 64'd1;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input bit priv, input logic [31:0] a,
                          input logic [63:0] d, input string req);
        exp_t e;
        bit hit;
        int idx;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_priv = priv; req_addr = a; req_wdata = d;
        idx = int'(a - A_FIX0);
        hit = (a == A_CFG) || (a == A_CNT) || (a == A_GS) || (a == A_KGS) || (a >= A_FIX0 && a < A_FIX0 + NF);
        e.req = req; e.valid = 1'b0; e.flt = 1'b0; e.data = '0;
        if (!priv || !hit) begin
            e.flt = 1'b1;
        end else begin
            e.valid = 1'b1;
            if (wr) begin
                if (a == A_CFG) cfg_m = d & 64'h3C_0000;
                else if (a == A_GS) gs_m = d;
                else if (a == A_KGS) kgs_m = d;
                else if (a != A_CNT) begin
                    if (cfg_m[19]) fix_m[idx] = d & rep(8'h1F);
                    else fix_m[idx] = (d & rep(8'h07)) | (fix_m[idx] & rep(8'h18));
                end
            end else begin
                if (a == A_CFG) e.data = cfg_m;
                else if (a == A_GS) e.data = gs_m;
                else if (a == A_KGS) e.data = kgs_m;
                else if (a == A_CNT) e.data = cnt_m;
                else e.data = cfg_m[19] ? fix_m[idx] : (fix_m[idx] & rep(8'h07));
            end
        end
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_priv = 1'b0;
    endtask

    // Monitor: compares the response of each edge with the scoreboard head
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check({e.req, " rsp_valid"}, 64'(rsp_valid), 64'(e.valid));
                check({e.req, " fault"}, 64'(fault), 64'(e.flt));
                check({e.req, " rdata"}, rsp_rdata, e.data);
            end else if (rsp_valid || fault) begin
                check("R10 unexpected response", 64'({rsp_valid, fault}), 64'd0);
            end
        end
    end

    task automatic check_en(input string req, input logic [3:0] exp);
        check(req, 64'({tom2_en, tom1_en, attr_mod_en, attr_en}), 64'(exp));
    endtask

    task automatic ucnt(input bit dis, input string req);
        logic [63:0] exp_d;
        @(negedge clk);
        ucnt_rd = 1'b1; tsc_dis = dis;
        exp_d = cnt_m;
        @(posedge clk);
        #1;
        check({req, " ucnt_valid"}, 64'(ucnt_valid), 64'(!dis));
        check({req, " ucnt_fault"}, 64'(ucnt_fault), 64'(dis));
        if (!dis) check({req, " ucnt_data"}, ucnt_data, exp_d);
        @(negedge clk);
        ucnt_rd = 1'b0; tsc_dis = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NF; i++) fix_m[i] = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R11 fault", 64'(fault), 64'd0);
        check_en("R11 enables", 4'h0);
        rst_n = 1'b1;
        access(0, 1, A_CFG, 0, "R11 cfg read");
        access(0, 1, A_GS, 0, "R11 gs read");
        access(0, 1, A_FIX0 + 2, 0, "R11 fix read");

        // R1 and R3: reserved bits dropped, enables follow
        access(1, 1, A_CFG, '1, "R10 cfg write");
        check_en("R3 all enables", 4'hF);
        access(0, 1, A_CFG, 0, "R1 cfg readback");

        // R2: attributes writable while modify is enabled
        access(1, 1, A_FIX0, '1, "R2 fix write mod on");
        access(0, 1, A_FIX0, 0, "R2 fix read mod on");
        access(1, 1, A_CFG, 64'h0004_0000, "R3 cfg attr only");
        check_en("R3 attr_en only", 4'h1);
        access(0, 1, A_FIX0, 0, "R2 fix read mod off");
        access(1, 1, A_FIX0, 64'h0102_0304_0506_0700, "R2 fix write mod off");
        access(1, 1, A_CFG, 64'h0028_0000, "R3 cfg mod+tom2");
        check_en("R3 mod and tom2", 4'hA);
        access(0, 1, A_FIX0, 0, "R2 attributes kept");
        access(1, 1, A_FIX0 + 3, 64'hA5A5_5A5A_1818_0707, "R2 fix3 write");
        access(0, 1, A_FIX0 + 3, 0, "R2 fix3 read");

        // R4: swap
        access(1, 1, A_GS, 64'h1111_2222_3333_4444, "R4 gs write");
        access(1, 1, A_KGS, 64'hAAAA_BBBB_CCCC_DDDD, "R4 kgs write");
        @(negedge clk); swap_gs = 1'b1;
        @(negedge clk); swap_gs = 1'b0;
        begin logic [63:0] t; t = gs_m; gs_m = kgs_m; kgs_m = t; end
        access(0, 1, A_GS, 0, "R4 gs after swap");
        access(0, 1, A_KGS, 0, "R4 kgs after swap");

        // R5 and R6: counter
        access(0, 1, A_CNT, 0, "R5 count read");
        repeat (5) @(negedge clk);
        access(0, 1, A_CNT, 0, "R5 count read later");
        access(1, 1, A_CNT, 64'hFFFF_FFFF_FFFF_FFF0, "R6 count load");
        access(0, 1, A_CNT, 0, "R6 count after load");
        repeat (20) @(negedge clk);
        access(0, 1, A_CNT, 0, "R6 count wraps");

        // R7: user counter read
        ucnt(1'b0, "R7 allowed");
        ucnt(1'b1, "R7 blocked");

        // R8: unprivileged requests
        access(1, 0, A_CFG, 0, "R8 unpriv cfg write");
        access(0, 1, A_CFG, 0, "R8 cfg unchanged");
        access(0, 0, A_GS, 0, "R8 unpriv read");

        // R9: unimplemented addresses
        access(0, 1, 32'h0000_1234, 0, "R9 bad read");
        access(1, 1, A_CFG + 1, '1, "R9 bad write");
        access(1, 1, A_FIX0 + NF, '1, "R9 past fix range");
        access(0, 1, A_CFG, 0, "R9 cfg unchanged");
        access(0, 1, A_FIX0 + 3, 0, "R9 fix unchanged");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule